// File: doc/BRIEF.md
# D-Channel Access Priority and Collision Detector

This block arbitrates access to a D-channel that several terminals share on one point-to-multipoint bus. While the local side is idle, it counts consecutive 1s arriving in the echo (E) bit stream. When a packet is armed and the run of 1s has reached the current priority threshold, the block grants start permission.

Once a packet has gone out successfully, the threshold rises by one. It falls back to the base value when a run of 1s reaches that raised value. Two traffic classes are supported, normal and low, and each has its own pair of thresholds.

While the local transmitter is active, every echoed E bit is compared with the D bit most recently sent. A mismatch is a collision. A collision sets a sticky status bit, raises a maskable interrupt and requests that the transmission be terminated. A loss of line synchronisation also requests termination. A collision that happens while an abort sequence is being sent is still recorded and still interrupts. In that case no termination request is issued, because the transmission is already being ended.

Top module: `dch_access_ctrl`

## Requirements
- R1: Each cycle with `e_strobe_i`=1 and `tx_active_i`=0 adds 1 to the run count when `e_bit_i`=1 (the count saturates at 15). When `e_bit_i`=0 the count goes back to 0, and permission drops.
- R2: `start_ok_o`=1 exactly when `arm_i`=1, `tx_active_i`=0 and the run count is at least the threshold. The base thresholds are 8 for the normal class (`class_low_i`=0) and 10 for the low class (`class_low_i`=1).
- R3: A cycle with `pkt_done_i`=1 raises the threshold to base+1, which is 9 for the normal class and 11 for the low class.
- R4: A raised threshold returns to the base value once a run of 1s reaches base+1.
- R5: While `tx_active_i`=1 the run count is held at 0. After a transmission, permission needs a fresh run of 1s that reaches the threshold.
- R6: In a cycle with `e_strobe_i`=1 and `tx_active_i`=1, an `e_bit_i` that differs from the last `d_bit_i` captured on `d_strobe_i` sets `col_status_o` from the next cycle on.
- R7: A matching echo bit, or any echo bit while `tx_active_i`=0, leaves `col_status_o` clear.
- R8: `col_status_o` stays set until a cycle with `status_rd_i`=1 clears it. If a new collision arrives in that same cycle, the status stays set.
- R9: `irq_o` is `col_status_o` gated by `col_mask_i`. When `col_mask_i`=0, `irq_o` is 0.
- R10: A collision while `abort_i`=1 still sets `col_status_o` and `irq_o`, but it raises no `terminate_o`.
- R11: `terminate_o` is 1 in the cycle after any cycle where `tx_active_i`=1, `abort_i`=0, and either a collision occurs or `sync_lost_i`=1. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| class_low_i | input | 1 | 1 selects the low priority class |
| arm_i | input | 1 | A packet is ready to send |
| pkt_done_i | input | 1 | One-cycle pulse when a packet finishes successfully |
| e_strobe_i | input | 1 | The echo bit is valid in this cycle |
| e_bit_i | input | 1 | Echo bit |
| d_strobe_i | input | 1 | The transmitted bit is valid in this cycle |
| d_bit_i | input | 1 | Transmitted D bit |
| tx_active_i | input | 1 | The local transmitter is sending |
| abort_i | input | 1 | An abort sequence is being sent |
| sync_lost_i | input | 1 | Line synchronisation is lost |
| col_mask_i | input | 1 | Collision interrupt enable |
| status_rd_i | input | 1 | Read of the collision status; clears it |
| start_ok_o | output | 1 | Permission to start the packet |
| col_status_o | output | 1 | Sticky collision status |
| terminate_o | output | 1 | Request to end the current transmission |
| irq_o | output | 1 | Masked collision interrupt |

## Verification
On every cycle, assertions check the following:
- the run count is cleared during transmission and after a 0 echo bit;
- a success pulse raises the threshold;
- a collision always leaves the status set in the following cycle;
- a read with no new collision clears the status;
- loss of sync during an unaborted transmission always produces a termination request, and an abort suppresses it.

The exact grant point for each class and threshold state can only be shown by the bench's sweeps over run lengths. The same holds for the drop back to the base threshold once a run reaches the raised value, the one-cycle width of the termination pulse, and the interrupt gating across all combinations of bit, echo, abort and mask.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic {
    CLS_NORMAL = 1'b0,
    CLS_LOW    = 1'b1
  } prio_cls_e;
endpackage

// File: rtl/dch_prio_counter.sv
module dch_prio_counter
  import dch_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int THR_NORM = 8,
  parameter int THR_LOW  = 10
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  prio_cls_e cls_i,
  input  logic      e_strobe_i,
  input  logic      e_bit_i,
  input  logic      tx_active_i,
  input  logic      pkt_done_i,
  output logic      reached_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BASE_N  = CNT_W'(THR_NORM);
  localparam logic [CNT_W-1:0] BASE_L  = CNT_W'(THR_LOW);

  logic [CNT_W-1:0] cnt_q, cnt_inc, base, hi_thr, thr;
  logic             elev_q;

  always_comb begin
    base    = (cls_i == CLS_LOW) ? BASE_L : BASE_N;
    hi_thr  = base + CNT_W'(1);
    thr     = elev_q ? hi_thr : base;
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (tx_active_i) cnt_q <= '0;
    else if (e_strobe_i)  cnt_q <= e_bit_i ? cnt_inc : '0;
  end

  // success raises the bar; a long enough idle run lowers it again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         elev_q <= 1'b0;
    else if (pkt_done_i) elev_q <= 1'b1;
    else if (!tx_active_i && e_strobe_i && e_bit_i && cnt_inc >= hi_thr)
      elev_q <= 1'b0;
  end

  assign reached_o = (cnt_q >= thr);

  assert_cnt_held_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |=> (cnt_q == '0));
  assert_zero_resets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_strobe_i && !e_bit_i) |=> (cnt_q == '0));
  assert_done_raises_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_i |=> elev_q);
endmodule

// File: rtl/dch_collision.sv
module dch_collision (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_strobe_i,
  input  logic d_bit_i,
  input  logic e_strobe_i,
  input  logic e_bit_i,
  input  logic tx_active_i,
  input  logic abort_i,
  input  logic sync_lost_i,
  input  logic mask_i,
  input  logic status_rd_i,
  output logic col_status_o,
  output logic irq_o,
  output logic term_o
);
  logic sent_q, col_q, term_q, col_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sent_q <= 1'b1;
    else if (d_strobe_i) sent_q <= d_bit_i;
  end

  assign col_ev = tx_active_i && e_strobe_i && (e_bit_i != sent_q);

  // new event wins over a simultaneous read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          col_q <= 1'b0;
    else if (col_ev)      col_q <= 1'b1;
    else if (status_rd_i) col_q <= 1'b0;
  end

  // abort already ends the frame, so no second request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) term_q <= 1'b0;
    else         term_q <= tx_active_i && !abort_i && (col_ev || sync_lost_i);
  end

  assign col_status_o = col_q;
  assign irq_o        = col_q & mask_i;
  assign term_o       = term_q;

  assert_col_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_ev |=> col_status_o);
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !col_ev) |=> !col_status_o);
  assert_sync_term_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_active_i && !abort_i && sync_lost_i) |=> term_o);
  assert_abort_noterm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !term_o);
endmodule

// File: rtl/dch_access_ctrl.sv
module dch_access_ctrl
  import dch_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int THR_NORM = 8,
  parameter int THR_LOW  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic class_low_i,
  input  logic arm_i,
  input  logic pkt_done_i,
  input  logic e_strobe_i,
  input  logic e_bit_i,
  input  logic d_strobe_i,
  input  logic d_bit_i,
  input  logic tx_active_i,
  input  logic abort_i,
  input  logic sync_lost_i,
  input  logic col_mask_i,
  input  logic status_rd_i,
  output logic start_ok_o,
  output logic col_status_o,
  output logic terminate_o,
  output logic irq_o
);
  prio_cls_e cls;
  logic      reached;

  assign cls = class_low_i ? CLS_LOW : CLS_NORMAL;

  dch_prio_counter #(
    .CNT_W(CNT_W), .THR_NORM(THR_NORM), .THR_LOW(THR_LOW)
  ) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .cls_i(cls),
    .e_strobe_i(e_strobe_i), .e_bit_i(e_bit_i),
    .tx_active_i(tx_active_i), .pkt_done_i(pkt_done_i),
    .reached_o(reached)
  );

  dch_collision u_col (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_strobe_i(d_strobe_i), .d_bit_i(d_bit_i),
    .e_strobe_i(e_strobe_i), .e_bit_i(e_bit_i),
    .tx_active_i(tx_active_i), .abort_i(abort_i),
    .sync_lost_i(sync_lost_i), .mask_i(col_mask_i),
    .status_rd_i(status_rd_i),
    .col_status_o(col_status_o), .irq_o(irq_o), .term_o(terminate_o)
  );

  assign start_ok_o = arm_i && !tx_active_i && reached;

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (col_status_o && col_mask_i));
endmodule

// File: tb/sim_dch_access_ctrl.sv
module sim_dch_access_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic class_low, arm, pkt_done, e_strobe, e_bit, d_strobe, d_bit;
  logic tx_active, abort_s, sync_lost, col_mask, status_rd;
  logic start_ok, col_status, terminate, irq;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  dch_access_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .class_low_i(class_low), .arm_i(arm),
    .pkt_done_i(pkt_done), .e_strobe_i(e_strobe), .e_bit_i(e_bit),
    .d_strobe_i(d_strobe), .d_bit_i(d_bit), .tx_active_i(tx_active),
    .abort_i(abort_s), .sync_lost_i(sync_lost), .col_mask_i(col_mask),
    .status_rd_i(status_rd), .start_ok_o(start_ok), .col_status_o(col_status),
    .terminate_o(terminate), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    {class_low, arm, pkt_done, e_strobe, e_bit, d_strobe, d_bit} = '0;
    {tx_active, abort_s, sync_lost, col_mask, status_rd} = '0;
    rst_ni = 1'b0; step(); rst_ni = 1'b1; step();
  endtask

  task automatic e_one(input logic b);
    e_strobe = 1'b1; e_bit = b; step(); e_strobe = 1'b0;
  endtask

  task automatic d_one(input logic b);
    d_strobe = 1'b1; d_bit = b; step(); d_strobe = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R2 reset start_ok", start_ok, 1'b0);
    chk("R6 reset col_status", col_status, 1'b0);
    chk("R11 reset terminate", terminate, 1'b0);
    chk("R9 reset irq", irq, 1'b0);

    // priority sweep: class x raised state x run length
    for (int cl = 0; cl < 2; cl++)
      for (int el = 0; el < 2; el++)
        for (int n = 0; n < 14; n++) begin
          int base, thr;
          bit still_raised;
          base = cl ? 10 : 8;
          thr  = base + el;
          do_reset();
          class_low = cl[0];
          if (el != 0) begin pkt_done = 1'b1; step(); pkt_done = 1'b0; end
          arm = 1'b1;
          for (int i = 0; i < n; i++) e_one(1'b1);
          chk("R2/R3 grant at threshold", start_ok, logic'(n >= thr));
          e_one(1'b0);
          chk("R1 zero resets run", start_ok, 1'b0);
          still_raised = (el != 0) && (n < base + 1);
          for (int i = 0; i < base; i++) e_one(1'b1);
          chk("R4 threshold drop", start_ok, logic'(!still_raised));
        end

    // not armed: no permission; saturation keeps grant
    do_reset();
    for (int i = 0; i < 20; i++) e_one(1'b1);
    chk("R2 unarmed", start_ok, 1'b0);
    arm = 1'b1; step();
    chk("R1 saturated run grants", start_ok, 1'b1);

    // R5: transmission clears the run
    do_reset();
    arm = 1'b1;
    for (int i = 0; i < 8; i++) e_one(1'b1);
    chk("R5 granted before tx", start_ok, 1'b1);
    tx_active = 1'b1; step();
    chk("R5 no grant during tx", start_ok, 1'b0);
    tx_active = 1'b0; step();
    chk("R5 recount needed", start_ok, 1'b0);
    for (int i = 0; i < 7; i++) e_one(1'b1);
    chk("R5 seven not enough", start_ok, 1'b0);
    e_one(1'b1);
    chk("R5 regranted", start_ok, 1'b1);

    // collision sweep
    for (int v = 0; v < 32; v++) begin
      logic db, eb, act, ab, mk, mm;
      {db, eb, act, ab, mk} = v[4:0];
      mm = act & (db ^ eb);
      do_reset();
      tx_active = act; abort_s = ab; col_mask = mk;
      d_one(db);
      e_one(eb);
      chk("R6/R7 col_status", col_status, mm);
      chk("R9/R10 irq", irq, mm & mk);
      chk("R10/R11 terminate", terminate, mm & ~ab);
      step();
      chk("R11 terminate pulse", terminate, 1'b0);
      chk("R8 sticky", col_status, mm);
      status_rd = 1'b1; step(); status_rd = 1'b0;
      chk("R8 read clears", col_status, 1'b0);
      chk("R9 irq after read", irq, 1'b0);
    end

    // R8: event beats simultaneous read
    do_reset();
    tx_active = 1'b1; col_mask = 1'b1;
    d_one(1'b0);
    status_rd = 1'b1; e_one(1'b1); status_rd = 1'b0;
    chk("R8 event wins over read", col_status, 1'b1);
    col_mask = 1'b0; #1;
    chk("R9 mask off", irq, 1'b0);

    // R11: sync loss
    do_reset();
    tx_active = 1'b1; sync_lost = 1'b1; step();
    chk("R11 sync lost terminates", terminate, 1'b1);
    sync_lost = 1'b0; step();
    chk("R11 sync term ends", terminate, 1'b0);
    abort_s = 1'b1; sync_lost = 1'b1; step();
    chk("R10 abort suppresses term", terminate, 1'b0);
    abort_s = 1'b0; tx_active = 1'b0; step();
    chk("R11 idle sync no term", terminate, 1'b0);
    chk("R7 idle no collision", col_status, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule